// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block computes byte addresses for data accesses from a small bank of pointer register sets. Each set holds an index, a base, a length and a modify value. A request selects a set, a modify register, a mode and an access size. The block returns the effective address one cycle later and may also advance the index register.

Advancing the index can wrap it around a circular buffer. The buffer can start at any byte address and have any length, and the wrap costs no extra cycles. A reverse-carry mode walks an index in bit-reversed order for FFT data shuffles. Register write ports load the four register kinds.

Top module: `circ_agen`

## Requirements
- R1: After reset, `addr_o`, `valid_o` and `misalign_o` are 0 and every index, base, length and modify register holds 0.
- R2: In post-modify mode (`mode_i`=1), the address is the current index. The index then becomes index+modify. If the buffer length is non-zero and the sum is at or above base+length, the length is subtracted from the sum.
- R3: In post-modify mode with a negative modify, if the sum drops below the base, the length is added back to it. The wrap assumes that the magnitude of the modify does not exceed the length.
- R4: A length register of zero disables wrapping, so the index advances linearly.
- R5: In index-only mode (`mode_i`=0), and for the reserved codes 5 to 7, the address is the current index and the index is unchanged.
- R6: In pre-offset mode (`mode_i`=2), the address is index+modify and the index is not written back.
- R7: In update-only mode (`mode_i`=3), no access is produced (`valid_o` stays 0). The index advances with the same wrap rule as post-modify.
- R8: In bit-reverse mode (`mode_i`=4), the address is the current index. The index then becomes the reverse-carry sum of index and modify, in which carries run from the most significant bit toward the least significant bit.
- R9: `misalign_o` is 1 only together with `valid_o`, and only for a misaligned access. A half-word access (`size_i`=1) is misaligned when address bit 0 is set. A word access (`size_i`=2 or 3) is misaligned when bits 1:0 are non-zero. A byte access (`size_i`=0) is never misaligned.
- R10: A register write selects the register with `wr_kind_i`: 0 index, 1 base, 2 length, 3 modify. Writing a base register also loads the same value into that set's index register.
- R11: If a register write and an index update hit the same set's index register in the same cycle, the written value wins.
- R12: The outputs are registered. A request in cycle N drives `valid_o`, `addr_o` and `misalign_o` in cycle N+1, and requests may be issued back to back. `valid_o` is 0 in any cycle that follows no access request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe |
| set_i | input | SW | Register set supplying index, base and length |
| mod_sel_i | input | SW | Register set supplying the modify value |
| mode_i | input | 3 | Addressing mode (see R2 to R8) |
| size_i | input | 2 | Access size (see R9) |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register kind written (see R10) |
| wr_set_i | input | SW | Register set written |
| wr_data_i | input | AW | Write data |
| addr_o | output | AW | Effective byte address |
| valid_o | output | 1 | Address valid |
| misalign_o | output | 1 | Misaligned access |

## Verification
The bench builds the block with its defaults: four register sets and 32-bit addresses, so SW is 2. With all four sets, each buffer scenario can stay in its own set, and the write-over-update collision can be staged on a set that already carries wrap state. The full 32-bit width makes the reverse-carry add span the whole word. A modify of 8 therefore shows carries moving downward from bit 3. The base register can also sit at a non-power-of-two address.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [2:0] {
    AM_IDX  = 3'd0,
    AM_POST = 3'd1,
    AM_PRE  = 3'd2,
    AM_UPD  = 3'd3,
    AM_BREV = 3'd4
  } agen_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } agen_size_e;

  typedef enum logic [1:0] {
    RK_IDX  = 2'd0,
    RK_BASE = 2'd1,
    RK_LEN  = 2'd2,
    RK_MOD  = 2'd3
  } agen_reg_e;
endpackage

// File: rtl/agen_regfile.sv
module agen_regfile
  import agen_pkg::*;
#(
  parameter int unsigned N_SETS = 4,
  parameter int unsigned AW     = 32,
  localparam int unsigned SW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [SW-1:0] wr_set_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [SW-1:0] upd_set_i,
  input  logic [AW-1:0] upd_val_i,
  output logic [AW-1:0] idx_o [N_SETS],
  output logic [AW-1:0] base_o[N_SETS],
  output logic [AW-1:0] len_o [N_SETS],
  output logic [AW-1:0] mod_o [N_SETS]
);
  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    logic wr_hit, upd_hit;
    assign wr_hit  = wr_en_i && (wr_set_i == SW'(g));
    assign upd_hit = upd_en_i && (upd_set_i == SW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        idx_o[g]  <= '0;
        base_o[g] <= '0;
        len_o[g]  <= '0;
        mod_o[g]  <= '0;
      end else begin
        // software write beats the pointer update
        if (wr_hit && (wr_kind_i == RK_IDX || wr_kind_i == RK_BASE))
          idx_o[g] <= wr_data_i;
        else if (upd_hit)
          idx_o[g] <= upd_val_i;
        if (wr_hit && wr_kind_i == RK_BASE) base_o[g] <= wr_data_i;
        if (wr_hit && wr_kind_i == RK_LEN)  len_o[g]  <= wr_data_i;
        if (wr_hit && wr_kind_i == RK_MOD)  mod_o[g]  <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/agen_wrap.sv
module agen_wrap #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] mod_i,
  output logic [AW-1:0] nxt_o
);
  localparam int unsigned XW = AW + 2;

  // two guard bits keep both bound compares exact across address zero
  logic signed [XW-1:0] i_x, b_x, l_x, m_x, sum_x, hi_x, dn_x, up_x;
  assign i_x   = $signed({2'b00, idx_i});
  assign b_x   = $signed({2'b00, base_i});
  assign l_x   = $signed({2'b00, len_i});
  assign m_x   = $signed({{2{mod_i[AW-1]}}, mod_i});
  assign sum_x = i_x + m_x;
  assign hi_x  = b_x + l_x;
  assign dn_x  = sum_x - l_x;
  assign up_x  = sum_x + l_x;

  always_comb begin
    nxt_o = sum_x[AW-1:0];
    if (len_i != '0) begin
      if (sum_x >= hi_x)     nxt_o = dn_x[AW-1:0];
      else if (sum_x < b_x)  nxt_o = up_x[AW-1:0];
    end
  end
endmodule

// File: rtl/agen_brev.sv
module agen_brev #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] a_r, b_r, s_r;

  for (genvar k = 0; k < AW; k++) begin : g_rev
    assign a_r[k]   = a_i[AW-1-k];
    assign b_r[k]   = b_i[AW-1-k];
    assign sum_o[k] = s_r[AW-1-k];
  end

  assign s_r = a_r + b_r;
endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import agen_pkg::*;
#(
  parameter int unsigned N_SETS = 4,
  parameter int unsigned AW     = 32,
  localparam int unsigned SW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [SW-1:0] set_i,
  input  logic [SW-1:0] mod_sel_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [SW-1:0] wr_set_i,
  input  logic [AW-1:0] wr_data_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o,
  output logic          misalign_o
);
  logic [AW-1:0] idx_a [N_SETS];
  logic [AW-1:0] base_a[N_SETS];
  logic [AW-1:0] len_a [N_SETS];
  logic [AW-1:0] mod_a [N_SETS];

  logic [AW-1:0] cur_idx, cur_base, cur_len, cur_mod;
  logic [AW-1:0] wrap_nxt, brev_nxt, pre_addr;
  logic [AW-1:0] ea, upd_val;
  logic          acc, upd, mis;

  agen_regfile #(.N_SETS(N_SETS), .AW(AW)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_kind_i (wr_kind_i),
    .wr_set_i  (wr_set_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (req_i && upd),
    .upd_set_i (set_i),
    .upd_val_i (upd_val),
    .idx_o     (idx_a),
    .base_o    (base_a),
    .len_o     (len_a),
    .mod_o     (mod_a)
  );

  assign cur_idx  = idx_a[set_i];
  assign cur_base = base_a[set_i];
  assign cur_len  = len_a[set_i];
  assign cur_mod  = mod_a[mod_sel_i];
  assign pre_addr = cur_idx + cur_mod;

  agen_wrap #(.AW(AW)) i_wrap (
    .idx_i  (cur_idx),
    .base_i (cur_base),
    .len_i  (cur_len),
    .mod_i  (cur_mod),
    .nxt_o  (wrap_nxt)
  );

  agen_brev #(.AW(AW)) i_brev (
    .a_i   (cur_idx),
    .b_i   (cur_mod),
    .sum_o (brev_nxt)
  );

  always_comb begin
    acc     = 1'b1;
    upd     = 1'b0;
    ea      = cur_idx;
    upd_val = wrap_nxt;
    case (mode_i)
      AM_POST: upd = 1'b1;
      AM_PRE:  ea  = pre_addr;
      AM_UPD: begin
        acc = 1'b0;
        upd = 1'b1;
      end
      AM_BREV: begin
        upd     = 1'b1;
        upd_val = brev_nxt;
      end
      default: ;
    endcase
  end

  always_comb begin
    case (size_i)
      SZ_BYTE: mis = 1'b0;
      SZ_HALF: mis = ea[0];
      default: mis = |ea[1:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o     <= '0;
      valid_o    <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      valid_o    <= req_i && acc;
      misalign_o <= req_i && acc && mis;
      if (req_i && acc) addr_o <= ea;
    end
  end
endmodule

// File: rtl/circ_agen_chk.sv
module circ_agen_chk #(
  parameter int unsigned N_SETS = 4,
  parameter int unsigned AW     = 32,
  localparam int unsigned SW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [SW-1:0] set_i,
  input logic [2:0]    mode_i,
  input logic [1:0]    size_i,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_o,
  input logic          valid_o,
  input logic          misalign_o
);
  p_access_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i != 3'd3) |=> valid_o);

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);

  p_upd_no_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 3'd3) |=> !valid_o);

  p_mis_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !misalign_o);

  p_byte_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i != 3'd3 && size_i == 2'd0) |=> !misalign_o);

  p_idx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 3'd0 && !wr_en_i) ##1
    (req_i && mode_i == 3'd0 && set_i == $past(set_i))
    |=> addr_o == $past(addr_o));
endmodule

bind circ_agen circ_agen_chk #(.N_SETS(N_SETS), .AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .set_i      (set_i),
  .mode_i     (mode_i),
  .size_i     (size_i),
  .wr_en_i    (wr_en_i),
  .addr_o     (addr_o),
  .valid_o    (valid_o),
  .misalign_o (misalign_o)
);

// File: tb/test_circ_agen.sv
module test_circ_agen;
  localparam int unsigned N_SETS = 4;
  localparam int unsigned AW     = 32;
  localparam int unsigned SW     = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req;
  logic [SW-1:0] set_s, msel;
  logic [2:0]    mode;
  logic [1:0]    size;
  logic          wr_en;
  logic [1:0]    wr_kind;
  logic [SW-1:0] wr_set;
  logic [AW-1:0] wr_data;
  logic [AW-1:0] addr_o;
  logic          valid_o, misalign_o;

  typedef struct {
    logic [AW-1:0] addr;
    logic          mis;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   run = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  circ_agen #(.N_SETS(N_SETS), .AW(AW)) i_circ_agen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .set_i      (set_s),
    .mod_sel_i  (msel),
    .mode_i     (mode),
    .size_i     (size),
    .wr_en_i    (wr_en),
    .wr_kind_i  (wr_kind),
    .wr_set_i   (wr_set),
    .wr_data_i  (wr_data),
    .addr_o     (addr_o),
    .valid_o    (valid_o),
    .misalign_o (misalign_o)
  );

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit r, input int s, input int ms, input int md, input int sz,
                      input bit w, input int wk, input int ws, input logic [AW-1:0] wd);
    @(negedge clk);
    req = r; set_s = SW'(s); msel = SW'(ms); mode = 3'(md); size = 2'(sz);
    wr_en = w; wr_kind = 2'(wk); wr_set = SW'(ws); wr_data = wd;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic wr(input int wk, input int ws, input logic [AW-1:0] wd);
    step(0, 0, 0, 0, 0, 1, wk, ws, wd);
  endtask

  task automatic acc(input int s, input int ms, input int md, input int sz,
                     input logic [AW-1:0] ea, input bit em, input string tag);
    step(1, s, ms, md, sz, 0, 0, 0, '0);
    exp_q.push_back('{ea, em, tag});
  endtask

  task automatic upd(input int s, input int ms);
    step(1, s, ms, 3, 0, 0, 0, 0, '0);
    idle();
    check(valid_o == 1'b0, "R7 update-only valid", {31'b0, valid_o}, '0);
  endtask

  // monitor: pops the scoreboard whenever the design presents an address
  always @(negedge clk) begin
    if (rst_n && run && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected valid", addr_o, '0);
      end else begin
        e = exp_q.pop_front();
        check(addr_o == e.addr, e.tag, addr_o, e.addr);
        check(misalign_o == e.mis, {e.tag, " misalign"}, {31'b0, misalign_o}, {31'b0, e.mis});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    req = 0; set_s = 0; msel = 0; mode = 0; size = 0;
    wr_en = 0; wr_kind = 0; wr_set = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(addr_o == '0, "R1 reset addr", addr_o, '0);
    check(valid_o == 1'b0, "R1 reset valid", {31'b0, valid_o}, '0);
    check(misalign_o == 1'b0, "R1 reset misalign", {31'b0, misalign_o}, '0);
    run = 1'b1;
    acc(2, 2, 0, 2, 32'h0, 0, "R1 index reset");
    acc(1, 1, 2, 2, 32'h0, 0, "R1 pre-offset reset");

    // set 0: base 0, length 44, modify 16
    wr(1, 0, 32'h0); wr(2, 0, 32'd44); wr(3, 0, 32'd16);
    acc(0, 0, 1, 2, 32'h00, 0, "R2 post 1");
    acc(0, 0, 1, 2, 32'h10, 0, "R2 post 2");
    acc(0, 0, 1, 2, 32'h20, 0, "R2 post 3");
    acc(0, 0, 1, 2, 32'h04, 0, "R2 post wrap");
    acc(0, 0, 1, 2, 32'h14, 0, "R2 post 5");

    // set 1: odd-placed base, index loaded through base write
    wr(1, 1, 32'h1000_0064); wr(2, 1, 32'd20); wr(3, 1, 32'd8);
    acc(1, 1, 1, 2, 32'h1000_0064, 0, "R10 base copies index");
    acc(1, 1, 1, 2, 32'h1000_006C, 0, "R2 odd base 2");
    acc(1, 1, 1, 2, 32'h1000_0074, 0, "R2 odd base 3");
    acc(1, 1, 1, 2, 32'h1000_0068, 0, "R2 odd base wrap");
    acc(1, 1, 1, 2, 32'h1000_0070, 0, "R2 odd base 5");
    acc(1, 1, 1, 2, 32'h1000_0064, 0, "R2 wrap at exact end");

    // set 2: negative modify
    wr(1, 2, 32'h200); wr(2, 2, 32'h30); wr(3, 2, 32'hFFFF_FFF0);
    acc(2, 2, 1, 2, 32'h200, 0, "R3 neg 1");
    acc(2, 2, 1, 2, 32'h220, 0, "R3 neg wrap up");
    acc(2, 2, 1, 2, 32'h210, 0, "R3 neg 3");
    acc(2, 2, 1, 2, 32'h200, 0, "R3 neg 4");

    // set 3: zero length, index-only, pre-offset, update-only
    wr(1, 3, 32'h100); wr(3, 3, 32'h40);
    acc(3, 3, 1, 2, 32'h100, 0, "R4 linear 1");
    acc(3, 3, 1, 2, 32'h140, 0, "R4 linear 2");
    acc(3, 3, 1, 2, 32'h180, 0, "R4 linear 3");
    acc(3, 3, 0, 2, 32'h1C0, 0, "R5 index only");
    acc(3, 3, 0, 2, 32'h1C0, 0, "R5 index unchanged");
    acc(3, 3, 7, 2, 32'h1C0, 0, "R5 reserved mode");
    acc(3, 3, 2, 2, 32'h200, 0, "R6 pre-offset addr");
    acc(3, 3, 0, 2, 32'h1C0, 0, "R6 no writeback");
    upd(3, 3);
    acc(3, 3, 0, 2, 32'h200, 0, "R7 update linear");

    // update-only with wrap on set 0 (index 0x24 -> 0x08)
    upd(0, 0);
    acc(0, 0, 0, 2, 32'h08, 0, "R7 update wrap");

    // bit-reversed walk on set 2
    wr(0, 2, 32'h0); wr(3, 2, 32'h8);
    acc(2, 2, 4, 0, 32'h0, 0, "R8 brev 0");
    acc(2, 2, 4, 0, 32'h8, 0, "R8 brev 1");
    acc(2, 2, 4, 0, 32'h4, 0, "R8 brev 2");
    acc(2, 2, 4, 0, 32'hC, 0, "R8 brev 3");
    acc(2, 2, 4, 0, 32'h2, 0, "R8 brev 4");
    acc(2, 2, 4, 0, 32'hA, 0, "R8 brev 5");

    // alignment on set 3 (modify 0x40)
    wr(0, 3, 32'h201);
    acc(3, 3, 0, 1, 32'h201, 1, "R9 half odd");
    acc(3, 3, 0, 0, 32'h201, 0, "R9 byte odd");
    acc(3, 3, 2, 2, 32'h241, 1, "R9 word pre-offset");
    wr(0, 3, 32'h202);
    acc(3, 3, 0, 2, 32'h202, 1, "R9 word off by two");
    acc(3, 3, 0, 3, 32'h202, 1, "R9 size code 3");
    acc(3, 3, 0, 1, 32'h202, 0, "R9 half even");

    // write collides with post-modify on set 0 (index 0x08)
    step(1, 0, 0, 1, 2, 1, 0, 0, 32'h500);
    exp_q.push_back('{32'h08, 1'b0, "R11 collision addr"});
    acc(0, 0, 0, 2, 32'h500, 0, "R11 write wins");
    wr(1, 0, 32'h300);
    acc(0, 0, 0, 2, 32'h300, 0, "R10 base write reloads index");

    idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 all results seen", AW'(exp_q.size()), '0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule